// File: doc/BRIEF.md
# Serial SAR ADC host controller

This block is the system-side master for a 12-bit successive-approximation converter that is read over a three-wire link: an active-low chip select, a serial clock and one serial data line from the converter. It derives the serial clock from the system clock with a fixed divider. After reset it waits out the converter's power-on time. It then runs one full throw-away frame to settle the converter's track-and-hold, and only then accepts work.

Once ready, the block runs a conversion when `start` is pulsed, or runs them back to back at a fixed pacing while `cont` is held. Every frame ends by raising chip select. The block then keeps chip select high for at least the acquisition time, so the converter can track its input before the next sample is taken. Each frame clocks out four leading zeros followed by the result, most significant bit first. The block removes the zeros and presents the result as a signed two's-complement sample with a one-cycle strobe. A short-frame option stops clocking after fewer result bits, which saves converter power; the missing low bits read as zero.

Top module: `sar_adc_host`

## Requirements
- R1: While reset is held, `adc_cs_n` and `adc_sclk` are high, `sample_valid` is low and `busy` is high.
- R2: After reset is released, `adc_cs_n` stays high for at least `PWRUP_CYC` system clocks before its first falling edge.
- R3: The first frame after reset is always a full 16-clock frame, even if `short_en` is high. It produces no `sample_valid`. `busy` stays high until the acquisition gap that follows it has ended.
- R4: `adc_sclk` is high whenever `adc_cs_n` is high. Its first falling edge in a frame comes `SCK_HALF` system clocks after `adc_cs_n` falls. Consecutive falling edges are `2*SCK_HALF` system clocks apart.
- R5: A full frame has exactly 16 serial clock falling edges. The converter presents frame bit k (k = 1..16) after falling edge k, and the block samples it at the following rising edge. Bits 1 to 4 are discarded. Bits 5 to 16 form `sample`[11:0], MSB first, as a two's-complement value.
- R6: When `short_en` is high as a frame is launched, that frame has 4+`SHORT_BITS` falling edges. `sample` then holds the received bits in its top `SHORT_BITS` positions, and its low 12-`SHORT_BITS` bits are zero.
- R7: Between a rising and the next falling edge of `adc_cs_n`, at least `ACQ_CYC` system clocks pass.
- R8: `sample_valid` is high for exactly one system clock per non-dummy frame. It is high in the same cycle in which `adc_cs_n` rises at the end of that frame.
- R9: A `start` pulse while `busy` is high is ignored. A `start` pulse while `busy` is low launches exactly one frame. `adc_cs_n` stays high while `busy` is low.
- R10: While `cont` is held high, successive `adc_cs_n` falling edges are max(`PERIOD_CYC`, 2*N*`SCK_HALF`+`ACQ_CYC`+1) system clocks apart, where N is the frame length in serial clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion (taken only when not busy) |
| cont | input | 1 | Hold high for back-to-back paced conversions |
| short_en | input | 1 | Use a short, reduced-resolution frame |
| busy | output | 1 | Bring-up, frame or acquisition gap in progress |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| sample | output | 12 | Signed conversion result |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock, idles high |
| adc_sdo | input | 1 | Serial data from the converter |

## Verification
A new request and the end of a conversion can arrive in the same cycle. A `start` pulse that lines up with the `sample_valid` strobe lands while the acquisition gap is still running, so it must be dropped rather than queued. The bench raises `start` in exactly the cycle in which it sees the strobe. It then judges the result by counting chip-select falling edges over the following idle window: that count must not increase, and the next deliberate `start` must still produce exactly one frame.

// File: rtl/sar_adc_host.sv
module sar_adc_host #(
  parameter int SCK_HALF   = 5,
  parameter int PWRUP_CYC  = 250000,
  parameter int ACQ_CYC    = 20,
  parameter int PERIOD_CYC = 200,
  parameter int SHORT_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cont,
  input  logic               short_en,
  output logic               busy,
  output logic               sample_valid,
  output logic signed [11:0] sample,
  output logic               adc_cs_n,
  output logic               adc_sclk,
  input  logic               adc_sdo
);
  localparam int RES   = 12;
  localparam int HDR   = 4;
  localparam int FULL  = HDR + RES;
  localparam int SLEN  = HDR + SHORT_BITS;
  localparam int TW    = $clog2(PWRUP_CYC + ACQ_CYC + 1);
  localparam int PW    = $clog2(PERIOD_CYC + 1);
  localparam int HW    = $clog2(SCK_HALF + 1);
  localparam int PHW   = $clog2(2 * FULL + 1);

  typedef enum logic [1:0] {S_PWR, S_IDLE, S_FRAME, S_ACQ} st_t;

  st_t             st;
  logic [TW-1:0]   tmr;
  logic [PW-1:0]   pc;
  logic [HW-1:0]   hc;
  logic [PHW-1:0]  ph;
  logic            dummy, short_q;
  logic [RES-1:0]  d, d_nxt;

  wire             half_end = hc == HW'(SCK_HALF - 1);
  wire [PHW-1:0]   ph_n     = ph + 1'b1;
  wire [PHW-1:0]   last_ph  = (short_q && !dummy) ? PHW'(2 * SLEN) : PHW'(2 * FULL);
  wire [PHW-2:0]   bit_no   = ph_n[PHW-1:1];
  wire             pace_ok  = pc == PW'(PERIOD_CYC - 1);
  wire             launch   = (st == S_IDLE) && (start || (cont && pace_ok));

  assign busy     = st != S_IDLE;
  assign adc_cs_n = st != S_FRAME;
  assign adc_sclk = !(st == S_FRAME && ph[0]);

  always_comb begin
    d_nxt = d;
    for (int i = 0; i < RES; i++)
      if (int'(bit_no) == FULL - i) d_nxt[i] = adc_sdo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_PWR;
      tmr          <= '0;
      pc           <= '0;
      hc           <= '0;
      ph           <= '0;
      dummy        <= 1'b1;
      short_q      <= 1'b0;
      d            <= '0;
      sample       <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (!pace_ok) pc <= pc + 1'b1;
      case (st)
        S_PWR: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(PWRUP_CYC - 1)) begin
            st <= S_FRAME;
            hc <= '0;
            ph <= '0;
            d  <= '0;
            pc <= '0;
          end
        end
        S_IDLE: if (launch) begin
          st      <= S_FRAME;
          hc      <= '0;
          ph      <= '0;
          d       <= '0;
          pc      <= '0;
          short_q <= short_en;
        end
        S_FRAME: begin
          hc <= half_end ? '0 : hc + 1'b1;
          if (half_end) begin
            ph <= ph_n;
            if (ph[0]) d <= d_nxt;
            if (ph_n == last_ph) begin
              st    <= S_ACQ;
              tmr   <= '0;
              dummy <= 1'b0;
              if (!dummy) begin
                sample_valid <= 1'b1;
                sample       <= $signed(d_nxt);
              end
            end
          end
        end
        default: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(ACQ_CYC - 1)) st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sar_adc_host_chk.sv
module sar_adc_host_chk #(
  parameter int ACQ_CYC = 20
) (
  input logic clk,
  input logic rst_n,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic busy,
  input logic sample_valid
);
  int   hi_cnt;
  int   fcnt;
  int   nfall;
  logic cs_p, sck_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 0;
      fcnt   <= 0;
      nfall  <= 0;
      cs_p   <= 1'b1;
      sck_p  <= 1'b1;
    end else begin
      cs_p  <= adc_cs_n;
      sck_p <= adc_sclk;
      if (!adc_cs_n) hi_cnt <= 0;
      else if (hi_cnt < ACQ_CYC) hi_cnt <= hi_cnt + 1;
      if (adc_cs_n) fcnt <= 0;
      else if (sck_p && !adc_sclk) fcnt <= fcnt + 1;
      if (cs_p && !adc_cs_n && nfall < 2) nfall <= nfall + 1;
    end
  end

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk);
  assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> fcnt <= 16);
  assert_acq_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> hi_cnt >= ACQ_CYC);
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  assert_valid_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> adc_cs_n && !$past(adc_cs_n));
  assert_no_dummy_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> nfall >= 2);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> adc_cs_n);
endmodule

bind sar_adc_host sar_adc_host_chk #(.ACQ_CYC(ACQ_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
  .busy(busy), .sample_valid(sample_valid)
);

// File: tb/tb_sar_adc_host.sv
module tb_sar_adc_host;
  localparam int T_HALF = 5, T_PWR = 400, T_ACQ = 20, T_PER = 200, T_SB = 8;

  logic clk = 0, rst_n = 0, start = 0, cont = 0, short_en = 0, adc_sdo = 0;
  logic busy, sample_valid, adc_cs_n, adc_sclk;
  logic signed [11:0] sample;

  sar_adc_host #(.SCK_HALF(T_HALF), .PWRUP_CYC(T_PWR), .ACQ_CYC(T_ACQ),
                 .PERIOD_CYC(T_PER), .SHORT_BITS(T_SB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cont(cont), .short_en(short_en),
    .busy(busy), .sample_valid(sample_valid), .sample(sample),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(adc_sdo));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_sample(logic [11:0] v, bit sh);
    logic [11:0] m = 12'hFFF << (12 - T_SB);
    return sh ? (v & m) : v;
  endfunction

  function automatic int min_gap(bit sh);
    int n = sh ? 4 + T_SB : 16;
    int f = 2 * n * T_HALF + T_ACQ + 1;
    return (f > T_PER) ? f : T_PER;
  endfunction

  // behavioural converter
  logic [11:0] next_val = 0, fval = 0;
  bit fshort = 0;
  int fidx = 0, fcnt = 0;
  always @(negedge adc_cs_n) begin
    fcnt = 0;
    fval = next_val;
    fshort = short_en && (fidx > 0);
    fidx++;
    adc_sdo = 0;
  end
  always @(negedge adc_sclk) if (!adc_cs_n) begin
    adc_sdo = (fcnt < 4 || fcnt > 15) ? 1'b0 : fval[15 - fcnt];
    fcnt++;
  end

  // monitor
  logic cs_p = 1, sck_p = 1, v_p = 0;
  int hi_run = 0, since_cs = 0, nf = 0, last_sck = 0, last_fall = 0, vcount = 0;
  bit first_fall = 1, prev_cont = 0, cont_meas = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) if (rst_n) begin
    if (cs_p && !adc_cs_n) begin
      if (first_fall) chk(hi_run >= T_PWR, "R2", "power-up wait", hi_run, T_PWR);
      else chk(hi_run >= T_ACQ, "R7", "acquisition gap", hi_run, T_ACQ);
      if (cont_meas && prev_cont)
        chk(cyc - last_fall == min_gap(fshort), "R10", "cont spacing", cyc - last_fall, min_gap(fshort));
      prev_cont = cont_meas;
      first_fall = 0;
      last_fall = cyc;
      since_cs = 0;
      nf = 0;
    end
    if (!adc_cs_n && sck_p && !adc_sclk) begin
      if (nf == 0) chk(since_cs == T_HALF, "R4", "cs to first fall", since_cs, T_HALF);
      else chk(cyc - last_sck == 2 * T_HALF, "R4", "sclk period", cyc - last_sck, 2 * T_HALF);
      last_sck = cyc;
      nf++;
    end
    if (!cs_p && adc_cs_n) begin
      chk(nf == (fshort ? 4 + T_SB : 16), fshort ? "R6" : "R5", "falls per frame", nf, fshort ? 4 + T_SB : 16);
      chk(adc_sclk, "R4", "sclk high after frame", adc_sclk, 1);
    end
    if (sample_valid) begin
      vcount++;
      chk(!v_p, "R8", "valid width", v_p, 0);
      chk(!cs_p && adc_cs_n, "R8", "valid with cs rise", adc_cs_n, 1);
      chk(fidx >= 2, "R3", "valid after dummy only", fidx, 2);
      chk(sample == $signed(exp_sample(fval, fshort)), fshort ? "R6" : "R5", "sample",
          sample, $signed(exp_sample(fval, fshort)));
    end
    hi_run = adc_cs_n ? hi_run + 1 : 0;
    since_cs++;
    cs_p = adc_cs_n; sck_p = adc_sclk; v_p = sample_valid;
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic single(logic [11:0] v, bit sh);
    int f0 = fidx, v0 = vcount;
    next_val = v; short_en = sh;
    pulse_start();
    wait_idle();
    chk(fidx == f0 + 1 && vcount == v0 + 1, "R9", "one frame per start", fidx - f0, 1);
  endtask

  initial begin
    int f0, v0, seed;
    seed = $urandom(32'd2024);
    short_en = 1;
    repeat (3) @(negedge clk);
    chk(adc_cs_n === 1'b1, "R1", "cs in reset", adc_cs_n, 1);
    chk(adc_sclk === 1'b1, "R1", "sclk in reset", adc_sclk, 1);
    chk(sample_valid === 1'b0, "R1", "valid in reset", sample_valid, 0);
    chk(busy === 1'b1, "R1", "busy in reset", busy, 1);
    rst_n = 1;
    wait_idle();
    chk(fidx == 1 && vcount == 0, "R3", "dummy frame silent", vcount, 0);

    foreach (next_val[i]) ;
    single(12'h800, 0); single(12'h7FF, 0); single(12'hFFF, 0); single(12'h000, 0);
    single(12'hFFF, 1); single(12'h801, 1);
    for (int i = 0; i < 12; i++) single(12'($urandom_range(4095, 0)), bit'($urandom_range(1, 0)));

    // start during a frame is ignored
    f0 = fidx; v0 = vcount;
    next_val = 12'h5A5; short_en = 0;
    pulse_start();
    repeat (30) @(negedge clk);
    start = 1; @(negedge clk) start = 0;
    wait_idle();
    repeat (50) @(negedge clk);
    chk(fidx == f0 + 1 && vcount == v0 + 1, "R9", "start while busy", fidx - f0, 1);

    // start coinciding with the valid strobe is ignored
    f0 = fidx;
    next_val = 12'h3C3;
    @(negedge clk) start = 1;
    do @(negedge clk); while (!sample_valid);
    start = 1;
    @(negedge clk) start = 0;
    wait_idle();
    repeat (50) @(negedge clk);
    chk(fidx == f0 + 1, "R9", "start on valid cycle", fidx - f0, 1);
    single(12'h123, 0);

    // continuous pacing
    v0 = vcount;
    next_val = 12'($urandom_range(4095, 0));
    cont_meas = 1; cont = 1;
    while (vcount < v0 + 8) begin
      @(negedge clk);
      if (sample_valid) begin
        next_val = 12'($urandom_range(4095, 0));
        short_en = bit'($urandom_range(1, 0));
      end
    end
    cont = 0; cont_meas = 0;
    wait_idle();
    repeat (T_PER) @(negedge clk);
    chk(!busy && adc_cs_n, "R9", "quiet after cont", busy, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule